// File: doc/BRIEF.md
# Paged-Segment Address Walker

This block turns a 34-bit logical address into a physical address. In this addressing scheme the segments are paged, and the segment table is paged as well. The logical address has four fields. From most to least significant they are: a segment-table page index (8 bits), a segment-table entry index (10 bits), a segment page index (6 bits) and a byte offset (10 bits). Every translation runs a fixed chain of three dependent word reads, and each read is indexed by a different field.

A request carries the logical address and the word address of the top-level table. The walker then uses one memory read port and keeps only one read outstanding. It waits for each response before it forms the address of the next read. The walk ends with a one-cycle result carrying either a physical address or a fault code that names where the walk stopped.

All table entries are 32-bit words with the same layout:
- bit 31 is the valid flag.
- bits 30:24 are a 7-bit limit, used only by segment-table entries.
- bits 23:0 are a pointer field. Its low 14 bits serve as a frame number where a frame is needed.

Top module: `pseg_walker`

## Requirements
- R1: Coming out of reset the walker shows `req_ready`=1, `mem_req`=0, `done_valid`=0, `done_fault`=0 and `done_paddr`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle `mem_req` is high for exactly one cycle, with `mem_addr` = `req_base` + s1, where s1 is `req_laddr`[33:26] and the sum wraps modulo 2^24.
- R3: Once a valid first-level word arrives, the second read address is {word[13:0], s2}, where s2 is `req_laddr`[25:16].
- R4: Once a valid segment-table word arrives and d1 (`req_laddr`[15:10]) is not greater than its limit (word[30:24]), the third read address is word[23:0] + d1, wrapping modulo 2^24.
- R5: When the third word is valid, the result has `done_fault`=0 and `done_paddr` = {word[13:0], d2}, where d2 is `req_laddr`[9:0].
- R6: A fetched word with bit 31 clear ends the walk with no further read. `done_fault` is 1, 2 or 3 for the first, second or third read, and `done_paddr` reads 0.
- R7: If d1 is greater than the segment-table word's limit, the walk ends after two reads with `done_fault`=4 and `done_paddr`=0. An entry that is not valid takes precedence over this check.
- R8: At most one read is outstanding. While a walk is in progress, `req_ready` is 0 and a new `req_valid` is ignored. A `mem_rvalid` that arrives while no read is pending has no effect.
- R9: `done_valid` rises in the cycle after the edge that samples the final response and lasts one cycle. The walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_laddr | input | 34 | Logical address {s1,s2,d1,d2} |
| req_base | input | 24 | Word address of the top-level table |
| mem_req | output | 1 | One-cycle read command |
| mem_addr | output | 24 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 24 | Physical address {frame, d2}, zero on fault |
| done_fault | output | 3 | 0 none, 1..3 invalid at that read, 4 length exceeded |

## Verification
The bench builds the walker with the package defaults: 8/10/6/10-bit fields, a 24-bit physical space and a 7-bit limit. These values bring two cases within reach. The first is a table base near the top of the space, so that base plus s1 wraps. The second is a d1 equal to and one above the limit, including the largest 6-bit page index against a limit of 63. Response latencies vary from one to five cycles to show that each read waits for the previous answer. Stray responses and requests arriving during a walk are also driven, to show that the walker ignores them.

// File: rtl/pseg_pkg.sv
package pseg_pkg;

    localparam int S1_W    = 8;
    localparam int S2_W    = 10;
    localparam int D1_W    = 6;
    localparam int D2_W    = 10;
    localparam int LA_W    = S1_W + S2_W + D1_W + D2_W;
    localparam int PA_W    = 24;
    localparam int ENTRY_W = 32;
    localparam int FRAME_W = PA_W - D2_W;
    localparam int LIM_W   = ENTRY_W - 1 - PA_W;
    localparam int FLT_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_L3   = 3'd3,
        ST_DONE = 3'd4
    } walk_state_e;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE = 3'd0,
        FLT_L1   = 3'd1,
        FLT_L2   = 3'd2,
        FLT_L3   = 3'd3,
        FLT_LEN  = 3'd4
    } fault_e;

    typedef struct packed {
        logic [S1_W-1:0] s1;
        logic [S2_W-1:0] s2;
        logic [D1_W-1:0] d1;
        logic [D2_W-1:0] d2;
    } laddr_t;

    typedef struct packed {
        logic             valid;
        logic [LIM_W-1:0] limit;
        logic [PA_W-1:0]  ptr;
    } entry_t;

    function automatic walk_state_e next_level(walk_state_e cur);
        case (cur)
            ST_L1:   return ST_L2;
            ST_L2:   return ST_L3;
            default: return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/pseg_entry_dec.sv
module pseg_entry_dec
    import pseg_pkg::*;
(
    input  logic [ENTRY_W-1:0] word,
    output entry_t             ent
);
    always_comb begin
        ent.valid = word[ENTRY_W-1];
        ent.limit = word[ENTRY_W-2 -: LIM_W];
        ent.ptr   = word[PA_W-1:0];
    end
endmodule

// File: rtl/pseg_step.sv
module pseg_step
    import pseg_pkg::*;
(
    input  walk_state_e      lvl,
    input  entry_t           ent,
    input  logic [S2_W-1:0]  s2,
    input  logic [D1_W-1:0]  d1,
    input  logic [D2_W-1:0]  d2,
    output logic [PA_W-1:0]  nxt_ptr,
    output fault_e           flt,
    output logic             fin
);
    always_comb begin
        nxt_ptr = ent.ptr;
        flt     = FLT_NONE;
        fin     = 1'b0;
        case (lvl)
            ST_L1: begin
                if (!ent.valid) begin
                    flt = FLT_L1;
                    fin = 1'b1;
                end else begin
                    nxt_ptr = {ent.ptr[FRAME_W-1:0], s2};
                end
            end
            ST_L2: begin
                if (!ent.valid) begin
                    flt = FLT_L2;
                    fin = 1'b1;
                end else if (LIM_W'(d1) > ent.limit) begin
                    flt = FLT_LEN;
                    fin = 1'b1;
                end else begin
                    nxt_ptr = ent.ptr + PA_W'(d1);
                end
            end
            ST_L3: begin
                fin = 1'b1;
                if (!ent.valid) begin
                    flt = FLT_L3;
                end else begin
                    nxt_ptr = {ent.ptr[FRAME_W-1:0], d2};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pseg_walker.sv
module pseg_walker
    import pseg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LA_W-1:0]     req_laddr,
    input  logic [PA_W-1:0]     req_base,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [ENTRY_W-1:0]  mem_rdata,
    output logic                done_valid,
    output logic [PA_W-1:0]     done_paddr,
    output logic [FLT_W-1:0]    done_fault
);
    walk_state_e      state;
    laddr_t           la_q;
    logic [PA_W-1:0]  ptr_q;
    logic             issue_q;
    logic [PA_W-1:0]  res_paddr;
    fault_e           res_fault;

    entry_t           ent;
    logic [PA_W-1:0]  nxt_ptr;
    fault_e           flt;
    logic             fin;
    laddr_t           la_in;

    assign la_in = laddr_t'(req_laddr);

    pseg_entry_dec u_dec (
        .word (mem_rdata),
        .ent  (ent)
    );

    pseg_step u_step (
        .lvl     (state),
        .ent     (ent),
        .s2      (la_q.s2),
        .d1      (la_q.d1),
        .d2      (la_q.d2),
        .nxt_ptr (nxt_ptr),
        .flt     (flt),
        .fin     (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            la_q      <= '0;
            ptr_q     <= '0;
            issue_q   <= 1'b0;
            res_paddr <= '0;
            res_fault <= FLT_NONE;
        end else begin
            issue_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        la_q    <= la_in;
                        ptr_q   <= req_base + PA_W'(la_in.s1);
                        issue_q <= 1'b1;
                        state   <= ST_L1;
                    end
                end
                ST_L1, ST_L2, ST_L3: begin
                    if (mem_rvalid) begin
                        if (fin) begin
                            state     <= ST_DONE;
                            res_fault <= flt;
                            res_paddr <= (flt == FLT_NONE) ? nxt_ptr : '0;
                        end else begin
                            ptr_q   <= nxt_ptr;
                            issue_q <= 1'b1;
                            state   <= next_level(state);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = issue_q;
    assign mem_addr   = ptr_q;
    assign done_valid = (state == ST_DONE);
    assign done_paddr = res_paddr;
    assign done_fault = res_fault;

endmodule

// File: rtl/pseg_walker_chk.sv
module pseg_walker_chk
    import pseg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               mem_req,
    input logic [PA_W-1:0]    mem_addr,
    input logic               mem_rvalid,
    input logic               done_valid,
    input logic [PA_W-1:0]    done_paddr,
    input logic [FLT_W-1:0]   done_fault
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_req && !done_valid));

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_fault_code_R6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != 3'd0) |-> (done_fault <= 3'd4 && done_paddr == '0));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !mem_rvalid && !done_valid) |=> $stable(mem_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));
endmodule

bind pseg_walker pseg_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .done_valid (done_valid),
    .done_paddr (done_paddr),
    .done_fault (done_fault)
);

// File: tb/pseg_walker_bench.sv
module pseg_walker_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  s1;
        logic [9:0]  s2;
        logic [5:0]  d1;
        logic [9:0]  d2;
        logic [23:0] base;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [31:0] e3;
        logic [23:0] paddr;
        logic [2:0]  fault;
        logic [1:0]  nrd;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h12, 10'h345, 6'h05, 10'h2AB, 24'h001000, 32'h80000123, 32'h8A040000, 32'h80002BCD, 24'hAF36AB, 3'd0, 2'd3, 4'd1},
        '{8'hFF, 10'h3FF, 6'h0A, 10'h3FF, 24'hFFFFF0, 32'h80003FFF, 32'h8A001000, 32'h80000001, 24'h0007FF, 3'd0, 2'd3, 4'd3},
        '{8'h00, 10'h000, 6'h0B, 10'h000, 24'h000000, 32'h80000001, 32'h8A002000, 32'h80000005, 24'h000000, 3'd4, 2'd2, 4'd2},
        '{8'h12, 10'h345, 6'h05, 10'h2AB, 24'h001000, 32'h00000123, 32'h8A040000, 32'h80002BCD, 24'h000000, 3'd1, 2'd1, 4'd1},
        '{8'h12, 10'h345, 6'h05, 10'h2AB, 24'h001000, 32'h80000123, 32'h0A040000, 32'h80002BCD, 24'h000000, 3'd2, 2'd2, 4'd5},
        '{8'h12, 10'h345, 6'h05, 10'h2AB, 24'h001000, 32'h80000123, 32'h8A040000, 32'h00002BCD, 24'h000000, 3'd3, 2'd3, 4'd2},
        '{8'h01, 10'h002, 6'h3F, 10'h155, 24'h000100, 32'h80000002, 32'hBF000100, 32'h80000010, 24'h004155, 3'd0, 2'd3, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [33:0] req_laddr = '0;
    logic [23:0] req_base = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done_valid;
    logic [23:0] done_paddr;
    logic [2:0]  done_fault;

    logic        mdl_rvalid = 1'b0;
    logic [31:0] mdl_rdata = '0;
    logic        inj_rvalid = 1'b0;
    logic [31:0] inj_rdata = '0;
    assign mem_rvalid = mdl_rvalid | inj_rvalid;
    assign mem_rdata  = inj_rvalid ? inj_rdata : mdl_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [int];
    int          lat_cur = 1;
    int          pend_cnt = 0;
    logic [23:0] pend_addr = '0;
    int          log_n = 0;
    logic [23:0] log_addr [64];
    int          overlap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pseg_walker u_pseg_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_base(req_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    // memory model: fixed latency, one response per command
    always @(posedge clk) begin
        mdl_rvalid <= 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mdl_rvalid <= 1'b1;
                mdl_rdata  <= mem.exists(int'(pend_addr)) ? mem[int'(pend_addr)] : 32'h0;
            end
        end
        if (mem_req) begin
            if (pend_cnt > 1) overlap <= overlap + 1;
            pend_addr <= mem_addr;
            pend_cnt  <= lat_cur;
            if (log_n < 64) log_addr[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input int vi, input bit poke);
        vec_t v;
        logic [23:0] a [3];
        int start_n;
        int n;
        bit busy_ok;
        v = VECS[vi];
        a[0] = v.base + 24'(v.s1);
        a[1] = {v.e1[13:0], v.s2};
        a[2] = v.e2[23:0] + 24'(v.d1);
        mem.delete();
        mem[int'(a[0])] = v.e1;
        mem[int'(a[1])] = v.e2;
        mem[int'(a[2])] = v.e3;
        lat_cur = int'(v.lat);
        start_n = log_n;
        @(negedge clk);
        req_laddr = {v.s1, v.s2, v.d1, v.d2};
        req_base  = v.base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        if (poke) begin
            @(negedge clk);
            busy_ok = !req_ready;
            req_laddr = '1;
            req_base  = 24'h555555;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy_ok, "R8", "req_ready while busy", longint'(!busy_ok), 0);
        end
        n = 0;
        while (!done_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(done_valid, "R9", $sformatf("vec%0d completion", vi), longint'(done_valid), 1);
        chk(done_fault == v.fault, (v.fault == 3'd4) ? "R7" : (v.fault != 3'd0 ? "R6" : "R5"),
            $sformatf("vec%0d fault", vi), longint'(done_fault), longint'(v.fault));
        chk(done_paddr == v.paddr, (v.fault == 3'd0) ? "R5" : "R6",
            $sformatf("vec%0d paddr", vi), longint'(done_paddr), longint'(v.paddr));
        chk(log_n - start_n == int'(v.nrd), "R6", $sformatf("vec%0d read count", vi),
            longint'(log_n - start_n), longint'(v.nrd));
        if (log_n - start_n >= 1)
            chk(log_addr[start_n] == a[0], "R2", $sformatf("vec%0d read1 addr", vi),
                longint'(log_addr[start_n]), longint'(a[0]));
        if (log_n - start_n >= 2)
            chk(log_addr[start_n+1] == a[1], "R3", $sformatf("vec%0d read2 addr", vi),
                longint'(log_addr[start_n+1]), longint'(a[1]));
        if (log_n - start_n >= 3)
            chk(log_addr[start_n+2] == a[2], "R4", $sformatf("vec%0d read3 addr", vi),
                longint'(log_addr[start_n+2]), longint'(a[2]));
        @(negedge clk);
        chk(!done_valid && req_ready, "R9", $sformatf("vec%0d done pulse width", vi),
            longint'({done_valid, req_ready}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", longint'(req_ready), 1);
        chk(mem_req == 1'b0 && done_valid == 1'b0, "R1", "mem_req/done_valid",
            longint'({mem_req, done_valid}), 0);
        chk(done_fault == 3'd0 && done_paddr == 24'd0, "R1", "result regs",
            longint'({done_fault, done_paddr}), 0);

        for (int i = 0; i < NV; i++) run_walk(i, 1'b0);

        // R8: stray response while idle
        @(negedge clk);
        inj_rdata  = 32'h80001234;
        inj_rvalid = 1'b1;
        @(negedge clk);
        inj_rvalid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!done_valid && req_ready && !mem_req, "R8", "stray rvalid while idle",
                longint'({done_valid, req_ready, mem_req}), 2);
            @(negedge clk);
        end

        // R8: request during walk is ignored, slow memory
        run_walk(6, 1'b1);
        run_walk(0, 1'b1);

        chk(overlap == 0, "R8", "overlapping reads", longint'(overlap), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule